// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps the active-lane mask of one warp while the warp runs through nested conditional code. Every lane runs both sides of a branch. The mask only decides which lanes are allowed to commit their results. The instruction stream drives the block with a two-bit marker code and a per-lane predicate vector, where each predicate bit comes from a lane's compare.

A divergent branch saves the current mask together with the predicate on a hardware stack. It then narrows the mask to the lanes whose predicate is true. At the else point the mask changes to the saved lanes whose predicate was false. At the reconvergence point the saved mask returns.

If a branch leaves no lane active, a one-cycle skip indication lets the sequencer bypass the taken path. Markers that the stack cannot honour leave all state untouched and set a sticky fault flag.

Top module: `simt_lane_mask`

## Requirements
- R1: After reset, `active_mask` is all ones, `skip_path` and `fault` are low, and the stack holds no entries.
- R2: `op` = 1 (enter branch) with the stack not full pushes the pair {current mask, `pred`}. One cycle later, `active_mask` equals the old mask AND `pred`.
- R3: `op` = 2 (else point) with a non-empty stack sets `active_mask` to the saved mask AND NOT the saved predicate of the top entry. The stack is left unchanged.
- R4: `op` = 3 (reconverge) with a non-empty stack restores `active_mask` to the saved mask of the top entry and removes that entry.
- R5: Branches nest up to DEPTH levels, and each reconvergence returns the mask of its own level in last-in, first-out order.
- R6: `op` = 1 with DEPTH entries already stored changes neither the mask nor the stack, and sets `fault`.
- R7: `op` = 3 on an empty stack changes neither the mask nor the stack, and sets `fault`.
- R8: `op` = 2 on an empty stack changes neither the mask nor the stack, and sets `fault`.
- R9: `skip_path` is high for exactly the one cycle after an accepted enter-branch whose resulting mask is all zeros, and low at all other times.
- R10: Once set, `fault` stays high until reset.
- R11: `op` = 0 (idle) leaves the mask and the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 2 | Marker: 0 idle, 1 enter branch, 2 else point, 3 reconverge |
| pred | input | LANES | Per-lane predicate; sampled on enter branch |
| active_mask | output | LANES | Lanes that may commit results |
| skip_path | output | 1 | Taken path has no active lane |
| fault | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench builds the block with LANES = 8 and DEPTH = 4. With a shallow stack, a run of short random marker sequences regularly fills the stack, empties it and overruns it. With a narrow mask, random predicates often drive the mask to all zeros, so the skip indication and the complement of a partly empty mask both get exercised. Directed sequences fix the exact mask values of a two-level nest before the randomized phase, and periodic resets in that phase clear the sticky flag.

// File: rtl/msk_pkg.sv
package msk_pkg;
  typedef enum logic [1:0] {
    MK_IDLE  = 2'd0,
    MK_ENTER = 2'd1,
    MK_ELSE  = 2'd2,
    MK_JOIN  = 2'd3
  } mark_e;
endpackage

// File: rtl/msk_lifo.sv
module msk_lifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  push_data,
  output logic [W-1:0]  top_data,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  slot [DEPTH];
  logic [CW-1:0] level_q;
  logic [IW-1:0] top_idx;

  assign top_idx  = IW'(level_q - 1'b1);
  assign top_data = slot[top_idx];
  assign level    = level_q;
  assign full     = (level_q == CW'(DEPTH));
  assign empty    = (level_q == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (push && (level_q == CW'(g)))
        slot[g] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      level_q <= '0;
    else if (push)
      level_q <= level_q + 1'b1;
    else if (pop)
      level_q <= level_q - 1'b1;
  end
endmodule

// File: rtl/msk_update.sv
module msk_update
  import msk_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [1:0]       op,
  input  logic [LANES-1:0] pred,
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] top_mask,
  input  logic [LANES-1:0] top_pred,
  input  logic             full,
  input  logic             empty,
  output logic [LANES-1:0] nxt_mask,
  output logic             push_ok,
  output logic             flip_ok,
  output logic             pop_ok,
  output logic             op_bad,
  output logic             push_zero
);
  function automatic logic [LANES-1:0] f_enter(input logic [LANES-1:0] m,
                                               input logic [LANES-1:0] p);
    return m & p;
  endfunction

  function automatic logic [LANES-1:0] f_other(input logic [LANES-1:0] m,
                                               input logic [LANES-1:0] p);
    return m & ~p;
  endfunction

  mark_e mk;
  assign mk = mark_e'(op);

  always_comb begin
    push_ok   = 1'b0;
    flip_ok   = 1'b0;
    pop_ok    = 1'b0;
    op_bad    = 1'b0;
    nxt_mask  = cur_mask;
    unique case (mk)
      MK_ENTER: begin
        if (full) op_bad = 1'b1;
        else begin
          push_ok  = 1'b1;
          nxt_mask = f_enter(cur_mask, pred);
        end
      end
      MK_ELSE: begin
        if (empty) op_bad = 1'b1;
        else begin
          flip_ok  = 1'b1;
          nxt_mask = f_other(top_mask, top_pred);
        end
      end
      MK_JOIN: begin
        if (empty) op_bad = 1'b1;
        else begin
          pop_ok   = 1'b1;
          nxt_mask = top_mask;
        end
      end
      default: ;
    endcase
    push_zero = push_ok && (nxt_mask == '0);
  end
endmodule

// File: rtl/msk_fault.sv
module msk_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic set_err,
  output logic fault
);
  always_ff @(posedge clk) begin
    if (!rst_n)       fault <= 1'b0;
    else if (set_err) fault <= 1'b1;
  end
endmodule

// File: rtl/simt_lane_mask.sv
module simt_lane_mask #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int EW   = 2 * LANES,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] active_mask,
  output logic             skip_path,
  output logic             fault
);
  logic [LANES-1:0] mask_q;
  logic             skip_q;
  logic [EW-1:0]    top_entry;
  logic [CW-1:0]    stack_level;
  logic             st_full, st_empty;
  logic [LANES-1:0] nxt_mask;
  logic             push_ok, flip_ok, pop_ok, op_bad, push_zero;

  msk_lifo #(.W(EW), .DEPTH(DEPTH)) u_lifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_ok),
    .pop       (pop_ok),
    .push_data ({pred, mask_q}),
    .top_data  (top_entry),
    .level     (stack_level),
    .full      (st_full),
    .empty     (st_empty)
  );

  msk_update #(.LANES(LANES)) u_upd (
    .op        (op),
    .pred      (pred),
    .cur_mask  (mask_q),
    .top_mask  (top_entry[LANES-1:0]),
    .top_pred  (top_entry[EW-1:LANES]),
    .full      (st_full),
    .empty     (st_empty),
    .nxt_mask  (nxt_mask),
    .push_ok   (push_ok),
    .flip_ok   (flip_ok),
    .pop_ok    (pop_ok),
    .op_bad    (op_bad),
    .push_zero (push_zero)
  );

  msk_fault u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_err (op_bad),
    .fault   (fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      skip_q <= 1'b0;
    end else begin
      if (push_ok || flip_ok || pop_ok) mask_q <= nxt_mask;
      skip_q <= push_zero;
    end
  end

  assign active_mask = mask_q;
  assign skip_path   = skip_q;
endmodule

// File: rtl/msk_checker.sv
module msk_checker #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] pred,
  input logic [LANES-1:0] active_mask,
  input logic             skip_path,
  input logic             fault,
  input logic             push_ok,
  input logic             flip_ok,
  input logic             pop_ok,
  input logic             op_bad,
  input logic [CW-1:0]    stack_level
);
  a_r2_push_and: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> active_mask == ($past(active_mask) & $past(pred)));

  a_r6_bad_holds: assert property (@(posedge clk) disable iff (!rst_n)
    op_bad |=> $stable(active_mask) && $stable(stack_level) && fault);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  a_r9_skip_cause: assert property (@(posedge clk) disable iff (!rst_n)
    skip_path |-> $past(push_ok) && (active_mask == '0));

  a_r4_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> stack_level == CW'($past(stack_level) - 1'b1));

  a_r3_flip_level: assert property (@(posedge clk) disable iff (!rst_n)
    flip_ok |=> $stable(stack_level));

  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stack_level <= CW'(DEPTH));

  a_r7_empty_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_level == '0) |-> !pop_ok && !flip_ok);
endmodule

bind simt_lane_mask msk_checker #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pred        (pred),
  .active_mask (active_mask),
  .skip_path   (skip_path),
  .fault       (fault),
  .push_ok     (push_ok),
  .flip_ok     (flip_ok),
  .pop_ok      (pop_ok),
  .op_bad      (op_bad),
  .stack_level (stack_level)
);

// File: tb/simt_lane_mask_test.sv
module simt_lane_mask_test;
  localparam int LANES  = 8;
  localparam int DEPTH  = 4;
  localparam int TCLK   = 10;
  localparam int WDOG   = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       op = 2'd0;
  logic [LANES-1:0] pred = '0;
  logic [LANES-1:0] active_mask;
  logic             skip_path;
  logic             fault;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // reference model state
  logic [LANES-1:0] m_mask;
  logic             m_skip;
  logic             m_err;
  logic [LANES-1:0] q_mask[$];
  logic [LANES-1:0] q_pred[$];

  simt_lane_mask #(.LANES(LANES), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .pred(pred),
    .active_mask(active_mask), .skip_path(skip_path), .fault(fault)
  );

  always #(TCLK/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected < %0d", cycles, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " mask"}, active_mask, m_mask);
    chk("R9 skip", LANES'(skip_path), LANES'(m_skip));
    chk("R10 fault", LANES'(fault), LANES'(m_err));
  endtask

  // R1: reset state
  task automatic do_reset();
    rst_n = 1'b0;
    op = 2'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_mask = '1; m_skip = 1'b0; m_err = 1'b0;
    q_mask.delete(); q_pred.delete();
    compare_all("R1");
  endtask

  // one marker per clock; model updated, outputs compared at next falling edge
  task automatic step(input logic [1:0] o, input logic [LANES-1:0] p);
    string tag;
    op = o; pred = p;
    m_skip = 1'b0;
    case (o)
      2'd1: if (q_mask.size() == DEPTH) begin m_err = 1'b1; tag = "R6"; end
            else begin
              q_mask.push_back(m_mask); q_pred.push_back(p);
              m_mask = m_mask & p; m_skip = (m_mask == '0); tag = "R2";
            end
      2'd2: if (q_mask.size() == 0) begin m_err = 1'b1; tag = "R8"; end
            else begin m_mask = q_mask[$] & ~q_pred[$]; tag = "R3"; end
      2'd3: if (q_mask.size() == 0) begin m_err = 1'b1; tag = "R7"; end
            else begin m_mask = q_mask.pop_back(); void'(q_pred.pop_back()); tag = "R4"; end
      default: tag = "R11";
    endcase
    @(negedge clk);
    op = 2'd0;
    compare_all(tag);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R2/R3/R4/R5: two-level nest with fixed values
    step(2'd1, 8'b1111_0000);   // mask F0
    step(2'd1, 8'b1100_1100);   // mask C0
    step(2'd2, 8'h00);          // F0 & ~CC = 30
    step(2'd3, 8'h00);          // back to F0
    step(2'd2, 8'h00);          // FF & ~F0 = 0F
    step(2'd3, 8'h00);          // back to FF
    chk("R5 nest returns all ones", active_mask, 8'hFF);
    step(2'd0, 8'hA5);          // R11 idle

    // R9: empty taken path
    step(2'd1, 8'h00);
    step(2'd0, 8'h00);
    step(2'd3, 8'h00);

    // R6: overrun the stack
    for (int i = 0; i < DEPTH; i++) step(2'd1, 8'hFF >> i);
    step(2'd1, 8'h01);
    // R7 / R8: drain then underflow
    for (int i = 0; i < DEPTH; i++) step(2'd3, 8'h00);
    step(2'd3, 8'h00);
    step(2'd2, 8'h00);
    step(2'd0, 8'h00);
    chk("R10 fault held", LANES'(fault), LANES'(1'b1));
    do_reset();

    // randomized marker streams
    for (int n = 0; n < 4000; n++) begin
      logic [LANES-1:0] p;
      p = LANES'($urandom);
      if ($urandom_range(0, 3) == 0) p = '1;
      step(2'($urandom_range(0, 3)), p);
      if (n % 400 == 399) do_reset();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule